// File: doc/BRIEF.md
# Per-Processor Interrupt Priority Presenter

This block sits beside one processor and decides whether that processor's interrupt request line should be high. It keeps two sets of sources. The first holds sources that are asking for service. The second holds sources whose handlers are running. It also holds a 4-bit threshold register that software writes. Each source reports its priority and vector when it activates. The block stores them and scans both sets for their highest priority. It then updates the request line at each event, following a rule that depends on the kind of event.

A source below the threshold still enters the requesting set. Lowering the threshold later then presents it without a new activation. A deactivation removes a source from the requesting set and re-evaluates the line. A deactivation means the source line fell or the source was masked. Software claims the best requesting source by strobing acknowledge. One cycle later the block returns either that source's vector or a fixed spurious vector. End-of-interrupt retires the highest-priority running handler.

Only one event is acted on per cycle. When several strobes arrive together, the order is acknowledge, then end-of-interrupt, then threshold write, then source event.

Top module: `ipp_presenter`

## Requirements
- R1: After reset the request line and the acknowledge-valid output are low, both sets are empty and the threshold is 0.
- R2: A threshold write keeps only bits [3:0] of the write data; the upper bits have no effect.
- R3: An activation whose priority is above the threshold and above the highest running priority (0 when none is running) drives the request line high in the next cycle.
- R4: An activation at or below the threshold leaves the request line unchanged but still enters the requesting set, so a later threshold write below its priority raises the line.
- R5: An activation whose priority is at or below the highest running priority leaves the request line unchanged.
- R6: Deactivating an active source removes it from the requesting set. The line then becomes high exactly when the remaining highest requesting priority exceeds both the threshold and the highest running priority.
- R7: Deactivating a source that is not active changes neither set nor the request line.
- R8: On a threshold write, the line drops if the highest requesting priority is at or below the new value. Otherwise it goes high if that priority exceeds the highest running priority, and otherwise it is unchanged.
- R9: Acknowledge produces a one-cycle ack_valid pulse in the next cycle. The winner is the requesting source of highest priority, with ties going to the lowest source index. The winner always leaves the requesting set. If it is valid, it joins the running set and its stored vector is returned.
- R10: If the requesting set is empty, or the winner's priority is not above the threshold, acknowledge returns SPUR_VEC (default 8'hFF) and nothing joins the running set.
- R11: After an acknowledge or an end-of-interrupt, the line is high exactly when the updated highest requesting priority exceeds both the threshold and the updated highest running priority.
- R12: End-of-interrupt removes the running source of highest priority (lowest index on ties).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_valid | input | 1 | Source event strobe |
| src_on | input | 1 | 1 = activation, 0 = deactivation or mask |
| src_id | input | IDW | Source index |
| src_prio | input | 4 | Source priority, valid on activation |
| src_vec | input | VEC_W | Source vector, valid on activation |
| tpr_we | input | 1 | Threshold write strobe |
| tpr_wdata | input | DATA_W | Threshold write data |
| ack_req | input | 1 | Acknowledge strobe |
| eoi_req | input | 1 | End-of-interrupt strobe |
| ack_valid | output | 1 | Acknowledge result valid |
| ack_vec | output | VEC_W | Returned vector or SPUR_VEC |
| irq | output | 1 | Interrupt request to the processor |

## Verification
Sources are activated at, above and below the threshold, and at, above and below the running priority. This separates the threshold comparison from the running-priority comparison. Threshold writes are driven down a path that drops the line, one that raises it and one that leaves it alone, with upper data bits set to show they are discarded. Two equal-priority sources are acknowledged to expose the tie order. Two handlers are stacked before end-of-interrupt, so that only clearing the higher one re-exposes a waiting source. A spurious acknowledge below the threshold is followed by an end-of-interrupt whose outcome differs if the winner had wrongly entered the running set.

// File: rtl/ipp_pkg.sv
package ipp_pkg;

    localparam int PRIO_W = 4;
    localparam int NSCAN  = 4;
    localparam int SC_RQ  = 0;   // requesting set, current
    localparam int SC_SQ  = 1;   // running set, current
    localparam int SC_RN  = 2;   // requesting set, after this cycle's event
    localparam int SC_SN  = 3;   // running set, after this cycle's event

    typedef logic [PRIO_W-1:0] prio_t;

    typedef enum logic [2:0] {
        EV_IDLE,
        EV_ACK,
        EV_EOI,
        EV_TPR,
        EV_SRC_ON,
        EV_SRC_OFF
    } ev_e;

    function automatic ev_e pick_event(logic ack, logic eoi, logic tpr,
                                       logic sv, logic son);
        if (ack)      return EV_ACK;
        else if (eoi) return EV_EOI;
        else if (tpr) return EV_TPR;
        else if (sv)  return son ? EV_SRC_ON : EV_SRC_OFF;
        else          return EV_IDLE;
    endfunction

    function automatic logic present(prio_t req_top, prio_t thr, prio_t run_top);
        return (req_top > thr) && (req_top > run_top);
    endfunction

endpackage

// File: rtl/ipp_scan.sv
module ipp_scan
    import ipp_pkg::*;
#(
    parameter int N   = 8,
    parameter int IDW = 3
) (
    input  logic [N-1:0]             mask,
    input  logic [N-1:0][PRIO_W-1:0] prio,
    output logic                     hit,
    output prio_t                    top,
    output logic [IDW-1:0]           idx
);
    // Strict compare keeps the lowest index among equal priorities.
    always_comb begin
        hit = 1'b0;
        top = '0;
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (mask[i] && (!hit || prio[i] > top)) begin
                hit = 1'b1;
                top = prio[i];
                idx = IDW'(i);
            end
        end
    end
endmodule

// File: rtl/ipp_srctab.sv
module ipp_srctab
    import ipp_pkg::*;
#(
    parameter int N    = 8,
    parameter int IDW  = 3,
    parameter int VW   = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     set_en,
    input  logic [IDW-1:0]           set_id,
    input  prio_t                    set_prio,
    input  logic [VW-1:0]            set_vec,
    input  logic                     clr_en,
    input  logic [IDW-1:0]           clr_id,
    output logic [N-1:0][PRIO_W-1:0] prio,
    output logic [N-1:0][VW-1:0]     vec,
    output logic [N-1:0]             active
);
    for (genvar g = 0; g < N; g++) begin : g_ent
        prio_t         p_q;
        logic [VW-1:0] v_q;
        logic          a_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                p_q <= '0;
                v_q <= '0;
                a_q <= 1'b0;
            end else if (set_en && set_id == IDW'(g)) begin
                p_q <= set_prio;
                v_q <= set_vec;
                a_q <= 1'b1;
            end else if (clr_en && clr_id == IDW'(g)) begin
                a_q <= 1'b0;
            end
        end

        assign prio[g]   = p_q;
        assign vec[g]    = v_q;
        assign active[g] = a_q;
    end
endmodule

// File: rtl/ipp_presenter.sv
module ipp_presenter
    import ipp_pkg::*;
#(
    parameter int               NSRC     = 8,
    parameter int               VEC_W    = 8,
    parameter int               DATA_W   = 32,
    parameter logic [VEC_W-1:0] SPUR_VEC = '1,
    localparam int              IDW      = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              src_valid,
    input  logic              src_on,
    input  logic [IDW-1:0]    src_id,
    input  logic [3:0]        src_prio,
    input  logic [VEC_W-1:0]  src_vec,
    input  logic              tpr_we,
    input  logic [DATA_W-1:0] tpr_wdata,
    input  logic              ack_req,
    input  logic              eoi_req,
    output logic              ack_valid,
    output logic [VEC_W-1:0]  ack_vec,
    output logic              irq
);
    ev_e                          ev;
    prio_t                        tpr_q, tpr_n;
    logic                         irq_q, irq_n;
    logic [NSRC-1:0]              raised_q, raised_n, serv_q, serv_n;
    logic                         ack_valid_q;
    logic [VEC_W-1:0]             ack_vec_q, ack_vec_n;
    logic                         ack_ok;
    logic                         clr_en;
    logic [IDW-1:0]               clr_id;

    logic [NSRC-1:0][PRIO_W-1:0]  tab_prio;
    logic [NSRC-1:0][VEC_W-1:0]   tab_vec;
    logic [NSRC-1:0]              tab_act;

    logic [NSRC-1:0]              sc_mask [NSCAN];
    logic                         sc_hit  [NSCAN];
    prio_t                        sc_top  [NSCAN];
    logic [IDW-1:0]               sc_idx  [NSCAN];

    assign ev = pick_event(ack_req, eoi_req, tpr_we, src_valid, src_on);

    ipp_srctab #(.N(NSRC), .IDW(IDW), .VW(VEC_W)) u_tab (
        .clk      (clk),
        .rst      (rst),
        .set_en   (ev == EV_SRC_ON),
        .set_id   (src_id),
        .set_prio (src_prio),
        .set_vec  (src_vec),
        .clr_en   (clr_en),
        .clr_id   (clr_id),
        .prio     (tab_prio),
        .vec      (tab_vec),
        .active   (tab_act)
    );

    assign sc_mask[SC_RQ] = raised_q;
    assign sc_mask[SC_SQ] = serv_q;
    assign sc_mask[SC_RN] = raised_n;
    assign sc_mask[SC_SN] = serv_n;

    for (genvar s = 0; s < NSCAN; s++) begin : g_scan
        ipp_scan #(.N(NSRC), .IDW(IDW)) u_scan (
            .mask (sc_mask[s]),
            .prio (tab_prio),
            .hit  (sc_hit[s]),
            .top  (sc_top[s]),
            .idx  (sc_idx[s])
        );
    end

    assign ack_ok = sc_hit[SC_RQ] && tab_act[sc_idx[SC_RQ]]
                 && (tab_prio[sc_idx[SC_RQ]] > tpr_q);

    // Set updates for this cycle's event.
    always_comb begin
        raised_n  = raised_q;
        serv_n    = serv_q;
        clr_en    = 1'b0;
        clr_id    = src_id;
        ack_vec_n = SPUR_VEC;
        case (ev)
            EV_SRC_ON:  raised_n[src_id] = 1'b1;
            EV_SRC_OFF: begin
                if (tab_act[src_id]) begin
                    raised_n[src_id] = 1'b0;
                    clr_en           = 1'b1;
                end
            end
            EV_ACK: begin
                if (sc_hit[SC_RQ]) begin
                    raised_n[sc_idx[SC_RQ]] = 1'b0;
                    if (ack_ok) begin
                        serv_n[sc_idx[SC_RQ]] = 1'b1;
                        ack_vec_n             = tab_vec[sc_idx[SC_RQ]];
                    end else begin
                        clr_en = 1'b1;
                        clr_id = sc_idx[SC_RQ];
                    end
                end
            end
            EV_EOI: begin
                if (sc_hit[SC_SQ]) serv_n[sc_idx[SC_SQ]] = 1'b0;
            end
            default: ;
        endcase
    end

    // Request line and threshold updates.
    always_comb begin
        irq_n = irq_q;
        tpr_n = tpr_q;
        case (ev)
            EV_SRC_ON: begin
                if (src_prio > tpr_q && src_prio > sc_top[SC_SQ]) irq_n = 1'b1;
            end
            EV_SRC_OFF: begin
                if (tab_act[src_id])
                    irq_n = present(sc_top[SC_RN], tpr_q, sc_top[SC_SN]);
            end
            EV_TPR: begin
                tpr_n = PRIO_W'(tpr_wdata);
                if (sc_top[SC_RQ] <= tpr_n)               irq_n = 1'b0;
                else if (sc_top[SC_RQ] > sc_top[SC_SQ])   irq_n = 1'b1;
            end
            EV_ACK, EV_EOI: irq_n = present(sc_top[SC_RN], tpr_q, sc_top[SC_SN]);
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tpr_q       <= '0;
            irq_q       <= 1'b0;
            raised_q    <= '0;
            serv_q      <= '0;
            ack_valid_q <= 1'b0;
            ack_vec_q   <= '0;
        end else begin
            tpr_q       <= tpr_n;
            irq_q       <= irq_n;
            raised_q    <= raised_n;
            serv_q      <= serv_n;
            ack_valid_q <= (ev == EV_ACK);
            if (ev == EV_ACK) ack_vec_q <= ack_vec_n;
        end
    end

    assign irq       = irq_q;
    assign ack_valid = ack_valid_q;
    assign ack_vec   = ack_vec_q;

    // Checks beside the logic they guard.
    assert_rise_R3: assert property (@(posedge clk) disable iff (rst)
        (ev == EV_SRC_ON && src_prio > tpr_q && src_prio > sc_top[SC_SQ]) |=> irq);

    assert_low_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (ev == EV_SRC_ON && src_prio <= tpr_q)
            |=> (raised_q[$past(src_id)] && irq == $past(irq)));

    assert_withdraw_R6: assert property (@(posedge clk) disable iff (rst)
        (ev == EV_SRC_OFF && tab_act[src_id]) |=> !raised_q[$past(src_id)]);

    assert_tpr_drop_R8: assert property (@(posedge clk) disable iff (rst)
        (ev == EV_TPR && sc_top[SC_RQ] <= PRIO_W'(tpr_wdata)) |=> !irq);

    assert_ack_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        ack_req |=> ack_valid);

    assert_empty_spur_R10: assert property (@(posedge clk) disable iff (rst)
        (ev == EV_ACK && !sc_hit[SC_RQ]) |=> (ack_vec == SPUR_VEC));

    assert_eoi_one_R12: assert property (@(posedge clk) disable iff (rst)
        (ev == EV_EOI && sc_hit[SC_SQ])
            |=> ($countones(serv_q) == $past($countones(serv_q)) - 1));
endmodule

// File: tb/sim_ipp_presenter.sv
module sim_ipp_presenter;
    localparam int NSRC  = 8;
    localparam int IDW   = 3;
    localparam int VEC_W = 8;
    localparam logic [VEC_W-1:0] SPUR = 8'hFF;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             src_valid = 1'b0, src_on = 1'b0;
    logic [IDW-1:0]   src_id = '0;
    logic [3:0]       src_prio = '0;
    logic [VEC_W-1:0] src_vec = '0;
    logic             tpr_we = 1'b0;
    logic [31:0]      tpr_wdata = '0;
    logic             ack_req = 1'b0, eoi_req = 1'b0;
    logic             ack_valid;
    logic [VEC_W-1:0] ack_vec;
    logic             irq;

    int n_chk = 0;
    int n_fail = 0;
    logic [VEC_W-1:0] exp_vec [$];
    string            exp_tag [$];

    always #5 clk = ~clk;

    ipp_presenter #(.NSRC(NSRC), .VEC_W(VEC_W), .DATA_W(32), .SPUR_VEC(SPUR)) u0 (
        .clk(clk), .rst(rst),
        .src_valid(src_valid), .src_on(src_on), .src_id(src_id),
        .src_prio(src_prio), .src_vec(src_vec),
        .tpr_we(tpr_we), .tpr_wdata(tpr_wdata),
        .ack_req(ack_req), .eoi_req(eoi_req),
        .ack_valid(ack_valid), .ack_vec(ack_vec), .irq(irq)
    );

    // Monitor: pops the scoreboard whenever a result appears.
    always @(negedge clk) begin
        if (!rst && ack_valid) begin
            n_chk++;
            if (exp_vec.size() == 0) begin
                n_fail++;
                $display("FAIL R9 unexpected ack_valid vec=%h expected none", ack_vec);
            end else begin
                automatic logic [VEC_W-1:0] e = exp_vec.pop_front();
                automatic string t = exp_tag.pop_front();
                if (ack_vec !== e) begin
                    n_fail++;
                    $display("FAIL %s ack_vec=%h expected %h", t, ack_vec, e);
                end
            end
        end
    end

    task automatic check_irq(input logic e, input string tag);
        n_chk++;
        if (irq !== e) begin
            n_fail++;
            $display("FAIL %s irq=%0b expected %0b", tag, irq, e);
        end
    endtask

    task automatic ev_on(input int id, input int p, input logic [VEC_W-1:0] v);
        @(negedge clk);
        src_valid = 1'b1; src_on = 1'b1; src_id = IDW'(id);
        src_prio = 4'(p); src_vec = v;
        @(negedge clk);
        src_valid = 1'b0;
    endtask

    task automatic ev_off(input int id);
        @(negedge clk);
        src_valid = 1'b1; src_on = 1'b0; src_id = IDW'(id);
        @(negedge clk);
        src_valid = 1'b0;
    endtask

    task automatic wr_tpr(input logic [31:0] d);
        @(negedge clk);
        tpr_we = 1'b1; tpr_wdata = d;
        @(negedge clk);
        tpr_we = 1'b0;
    endtask

    task automatic do_ack(input logic [VEC_W-1:0] e, input string tag);
        @(negedge clk);
        exp_vec.push_back(e);
        exp_tag.push_back(tag);
        ack_req = 1'b1;
        @(negedge clk);
        ack_req = 1'b0;
    endtask

    task automatic do_eoi();
        @(negedge clk);
        eoi_req = 1'b1;
        @(negedge clk);
        eoi_req = 1'b0;
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check_irq(1'b0, "R1");
        n_chk++;
        if (ack_valid !== 1'b0) begin
            n_fail++;
            $display("FAIL R1 ack_valid=%0b expected 0", ack_valid);
        end

        do_ack(SPUR, "R10 empty set");      check_irq(1'b0, "R11");
        ev_on(2, 5, 8'h22);                 check_irq(1'b1, "R3");
        do_ack(8'h22, "R9");                check_irq(1'b0, "R11 after ack");
        ev_on(3, 4, 8'h33);                 check_irq(1'b0, "R5 below running");
        ev_on(4, 5, 8'h44);                 check_irq(1'b0, "R5 equal running");
        ev_on(5, 7, 8'h55);                 check_irq(1'b1, "R3 above running");
        ev_off(5);                          check_irq(1'b0, "R6 drop");
        do_eoi();                           check_irq(1'b1, "R11 after eoi");
        wr_tpr(32'h0000_01A5);              check_irq(1'b0, "R2 R8 drop");
        ev_on(6, 3, 8'h66);                 check_irq(1'b0, "R4 held");
        wr_tpr(32'h0000_0002);              check_irq(1'b1, "R4 R8 raise");
        ev_on(1, 5, 8'h11);                 check_irq(1'b1, "R3");
        do_ack(8'h11, "R9 tie lowest index"); check_irq(1'b0, "R11");
        do_eoi();                           check_irq(1'b1, "R11");
        ev_off(7);                          check_irq(1'b1, "R7 inactive off");
        do_ack(8'h44, "R9");                check_irq(1'b0, "R11");
        do_ack(8'h33, "R9");                check_irq(1'b0, "R11");
        wr_tpr(32'h0);                      check_irq(1'b0, "R8 unchanged");
        ev_on(7, 5, 8'h77);                 check_irq(1'b0, "R5");
        do_eoi();                           check_irq(1'b1, "R12 highest cleared");
        wr_tpr(32'h9);                      check_irq(1'b0, "R8 drop");
        do_ack(SPUR, "R10 below threshold"); check_irq(1'b0, "R11");
        wr_tpr(32'h0);                      check_irq(1'b0, "R8 unchanged");
        do_eoi();                           check_irq(1'b1, "R10 spurious not serviced");
        ev_on(0, 9, 8'h0A);                 check_irq(1'b1, "R3");
        ev_off(6);                          check_irq(1'b1, "R6 stays");
        ev_off(0);                          check_irq(1'b0, "R6 empty");
        ev_off(7);                          check_irq(1'b0, "R7");
        wr_tpr(32'hFFFF_FFF1);              check_irq(1'b0, "R2");
        ev_on(2, 1, 8'h22);                 check_irq(1'b0, "R2 R4 at threshold");
        ev_on(5, 2, 8'h5A);                 check_irq(1'b1, "R2 R3");
        do_ack(8'h5A, "R9");                check_irq(1'b0, "R11");
        do_ack(SPUR, "R10 below threshold"); check_irq(1'b0, "R11");
        @(negedge clk);
        n_chk++;
        if (exp_vec.size() != 0) begin
            n_fail++;
            $display("FAIL R9 pending results=%0d expected 0", exp_vec.size());
        end
        finish_run();
    end
endmodule